// File: doc/BRIEF.md
# I2C Register Target with Key-Guarded Register

This block is an I2C target for a small byte-addressed register file. SCL and SDA are sampled by a fast system clock and pass through two synchroniser flops. START and STOP are found from SDA edges while SCL is high. SDA is pulled low through an open-drain enable. The bus master sends the device address, then a register pointer, then data bytes. To read, the master sets the pointer and then reads from it through a repeated START.

The file has ten general registers at 0x00–0x09 and a special window at 0x20–0x22. The registers at 0x00–0x06 hold time-of-day data, and the `backup_i` input fences them off from the bus. The register at 0x22 accepts a write only after a two-byte key sequence, and every write to it uses that key up. All registers reset to 0x00.

Top module: `i2c_keyreg_target`

## Requirements
- R1: The target acknowledges only the address byte 0xD0 (write) or 0xD1 (read), which is the 7-bit address 0x68 plus the direction bit in bit 0. Any other address, including the general call 0x00, gets no acknowledge, and the target stays idle until the next START.
- R2: In a write transfer, the first byte after the address loads the register pointer and every later byte is data. A read transfer returns the register selected by the pointer, MSB first. SDA is only pulled low while the target sends an ACK or a 0 data bit, and the enable only changes while SCL is low.
- R3: The pointer increments after every data byte, both written and read. It wraps from 0x09 to 0x00 and from 0x22 to 0x20, and any other value simply counts up.
- R4: A data byte is committed only at the end of its acknowledge clock. A STOP received part-way through a byte leaves the register file unchanged.
- R5: The key registers 0x20 and 0x21 always read as 0x00. Addresses outside 0x00–0x09 and 0x20–0x22 read as 0x00, and writes to them have no effect.
- R6: A write to 0x22 takes effect only when it follows a write of 0x5E to 0x20 and then a write of 0xC7 to 0x21. Each write to 0x22 uses up the unlock, whether or not the write took effect. A completed unlock is kept across a STOP.
- R7: The unlock progress returns to the start in three cases: a write that is not the expected next key byte, keys given in the wrong order, or a STOP between the two key writes.
- R8: While `backup_i` is high, writes to 0x00–0x06 are ignored and reads of them return 0x00. Addresses are still acknowledged, and the other registers work as normal.
- R9: A START in the middle of a transfer, including one inside a byte, returns the target to address reception. The pointer keeps the value it was last loaded with.
- R10: After reset, every register reads 0x00, the unlock progress is clear, and SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| backup_i | input | 1 | High while on backup power; fences the timekeeping registers |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
The bench targets the pointer wrap points at 0x09 and 0x22. A design that skips a wrap reads zeros from an unimplemented address where stored data should appear. It also sends key sequences in several forms: one burst, the wrong order across repeated STARTs, a wrong key value, and a STOP between the two keys. A design with a lax unlock would overwrite the value already held in 0x22. It cuts off a byte with a STOP and also with a repeated START. A design that commits early would corrupt the register, and one that does not resynchronise on START would read the wrong byte. Backup mode is toggled around writes and reads of the timekeeping registers, to catch a leaking write or an unmasked read.

// File: rtl/i2c_keyreg_target.sv
module i2c_keyreg_target #(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter logic [7:0] KEY_A    = 8'h5E,
  parameter logic [7:0] KEY_B    = 8'hC7,
  parameter int         NREG     = 10,
  parameter int         TK_REGS  = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic backup_i,
  output logic sda_oe
);
  localparam int         IW       = $clog2(NREG);
  localparam logic [7:0] LAST     = 8'(NREG - 1);
  localparam logic [7:0] TK_LAST  = 8'(TK_REGS - 1);
  localparam logic [7:0] WIN_A    = 8'h20;
  localparam logic [7:0] WIN_B    = 8'h21;
  localparam logic [7:0] WIN_S    = 8'h22;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WR, S_ACK, S_RD, S_MACK} st_t;

  st_t                    st;
  logic [1:0]             scl_p, sda_p;
  logic                   scl_s, sda_s, scl_q, sda_q;
  logic [3:0]             cnt;
  logic [7:0]             sh, tx, ptr, spec, rd_data, nxt;
  logic                   rw, addr_ph, first, nack;
  logic [1:0]             kst;
  logic [NREG-1:0][7:0]   regs;

  assign scl_s = scl_p[1];
  assign sda_s = sda_p[1];

  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire tk_block  = backup_i && (ptr <= TK_LAST);

  assign sda_oe = (st == S_ACK) || (st == S_RD && !tx[7]);
  assign nxt    = (ptr == LAST) ? 8'h00 : (ptr == WIN_S) ? WIN_A : ptr + 8'd1;

  always_comb begin
    rd_data = 8'h00;
    if (ptr <= LAST && !tk_block) rd_data = regs[ptr[IW-1:0]];
    else if (ptr == WIN_S)        rd_data = spec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 2'b11; sda_p <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
      st <= S_IDLE; cnt <= '0; sh <= '0; tx <= '0; ptr <= '0;
      rw <= 1'b0; addr_ph <= 1'b0; first <= 1'b0; nack <= 1'b0;
      kst <= 2'd0; spec <= '0; regs <= '0;
    end else begin
      scl_p <= {scl_p[0], scl_i};
      sda_p <= {sda_p[0], sda_i};
      scl_q <= scl_s;
      sda_q <= sda_s;
      if (stop_det) begin
        st <= S_IDLE;
        if (kst == 2'd1) kst <= 2'd0;
      end else if (start_det) begin
        st  <= S_ADDR;
        cnt <= '0;
      end else begin
        case (st)
          S_ADDR, S_WR: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (st == S_ADDR) begin
                if (sh[7:1] == DEV_ADDR) begin
                  st <= S_ACK; addr_ph <= 1'b1; rw <= sh[0];
                end else st <= S_IDLE;
              end else begin
                st <= S_ACK; addr_ph <= 1'b0;
              end
            end
          end
          S_ACK: if (scl_fall) begin
            if (addr_ph) begin
              if (rw) begin tx <= rd_data; st <= S_RD; end
              else    begin st <= S_WR; first <= 1'b1; end
            end else begin
              st <= S_WR;
              if (first) begin
                ptr <= sh; first <= 1'b0;
              end else begin
                ptr <= nxt;
                if (ptr <= LAST) begin
                  if (!tk_block) regs[ptr[IW-1:0]] <= sh;
                  kst <= 2'd0;
                end else if (ptr == WIN_A) begin
                  kst <= (sh == KEY_A) ? 2'd1 : 2'd0;
                end else if (ptr == WIN_B) begin
                  kst <= (sh == KEY_B && kst == 2'd1) ? 2'd2 : 2'd0;
                end else if (ptr == WIN_S) begin
                  if (kst == 2'd2) spec <= sh;
                  kst <= 2'd0;
                end else kst <= 2'd0;
              end
            end
          end
          S_RD: if (scl_fall) begin
            tx <= {tx[6:0], 1'b0};
            if (cnt == 4'd7) begin
              cnt <= '0; st <= S_MACK; ptr <= nxt;
            end else cnt <= cnt + 4'd1;
          end
          S_MACK: begin
            if (scl_rise) nack <= sda_s;
            else if (scl_fall) begin
              if (nack) st <= S_IDLE;
              else begin tx <= rd_data; st <= S_RD; end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_keyreg_target_chk.sv
module i2c_keyreg_target_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sda_oe,
  input logic        scl_s,
  input logic        stop_det,
  input logic        backup_i,
  input logic [1:0]  kst,
  input logic [7:0]  spec,
  input logic [55:0] tk
);
  // R10
  sda_rel_in_reset_chk: assert property (@(posedge clk) !rst_n |=> !sda_oe);
  // R2
  sda_moves_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);
  // R6
  spec_needs_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spec) |-> $past(kst) == 2'd2);
  // R7
  stop_clears_half_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && kst == 2'd1) |=> kst == 2'd0);
  // R8
  tk_frozen_in_backup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    backup_i |=> $stable(tk));
endmodule

bind i2c_keyreg_target i2c_keyreg_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s),
  .stop_det(stop_det), .backup_i(backup_i), .kst(kst), .spec(spec),
  .tk(regs[6:0])
);

// File: tb/tb_i2c_keyreg_target.sv
module tb_i2c_keyreg_target;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 80;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, backup = 1'b0;
  logic sda_oe;
  logic sda_bus;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_keyreg_target dut (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
                         .backup_i(backup), .sda_oe(sda_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { logic [7:0] v; string tag; } exp_t;
  exp_t       exp_q[$];
  logic [7:0] act_q[$];

  initial forever begin
    @(negedge clk);
    while (act_q.size() > 0) begin
      logic [7:0] a;
      a = act_q.pop_front();
      checks++;
      if (exp_q.size() == 0) begin
        errors++; $display("FAIL unexpected item: got %02h expected none", a);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (a !== e.v) begin
          errors++; $display("FAIL %s: got %02h expected %02h", e.tag, a, e.v);
        end
      end
    end
  end

  task automatic push(input logic [7:0] e, input logic [7:0] a, input string tag);
    exp_t x;
    x.v = e; x.tag = tag;
    exp_q.push_back(x);
    act_q.push_back(a);
  endtask

  task automatic wbit(input logic b);
    sda_m = b; #Q; scl = 1'b1; #Q; #Q; scl = 1'b0; #Q;
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; #Q; scl = 1'b1; #Q; sda_m = 1'b0; #Q; scl = 1'b0; #Q;
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; #Q; scl = 1'b1; #Q; sda_m = 1'b1; #Q;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
    logic a;
    for (int i = 7; i >= 0; i--) wbit(b[i]);
    sda_m = 1'b1; #Q; scl = 1'b1; #Q; a = sda_bus; #Q; scl = 1'b0; #Q;
    push({7'd0, exp_ack}, {7'd0, a}, tag);
  endtask

  task automatic recv_byte(input logic last, input logic [7:0] e, input string tag);
    logic [7:0] d;
    d = '0;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      #Q; scl = 1'b1; #Q; d = {d[6:0], sda_bus}; #Q; scl = 1'b0; #Q;
    end
    push(e, d, tag);
    wbit(last);
  endtask

  task automatic wr1(input logic [7:0] a, input logic [7:0] d, input string tag);
    i2c_start(); send_byte(8'hD0, 1'b0, tag); send_byte(a, 1'b0, tag);
    send_byte(d, 1'b0, tag); i2c_stop();
  endtask

  task automatic rd1(input logic [7:0] a, input logic [7:0] e, input string tag);
    i2c_start(); send_byte(8'hD0, 1'b0, tag); send_byte(a, 1'b0, tag);
    i2c_start(); send_byte(8'hD1, 1'b0, tag); recv_byte(1'b1, e, tag); i2c_stop();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    checks++;
    if (sda_oe !== 1'b0) begin errors++; $display("FAIL R10: got sda_oe=%b expected 0", sda_oe); end
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    rd1(8'h07, 8'h00, "R10 reg 07 after reset");
    rd1(8'h22, 8'h00, "R10 reg 22 after reset");

    // R1: foreign and general-call addresses are not acknowledged
    i2c_start(); send_byte(8'hA0, 1'b1, "R1 foreign addr"); i2c_stop();
    i2c_start(); send_byte(8'h00, 1'b1, "R1 general call"); i2c_stop();

    // R2: single write and read
    wr1(8'h03, 8'hA5, "R2 write 03");
    rd1(8'h03, 8'hA5, "R2 readback 03");

    // R3: burst write wraps 09 -> 00, burst read follows
    i2c_start(); send_byte(8'hD0, 1'b0, "R3"); send_byte(8'h08, 1'b0, "R3");
    send_byte(8'h11, 1'b0, "R3"); send_byte(8'h22, 1'b0, "R3"); send_byte(8'h33, 1'b0, "R3");
    i2c_stop();
    i2c_start(); send_byte(8'hD0, 1'b0, "R3"); send_byte(8'h08, 1'b0, "R3");
    i2c_start(); send_byte(8'hD1, 1'b0, "R3");
    recv_byte(1'b0, 8'h11, "R3 rd 08"); recv_byte(1'b0, 8'h22, "R3 rd 09");
    recv_byte(1'b1, 8'h33, "R3 rd wrap 00"); i2c_stop();

    // R4: STOP inside a data byte
    wr1(8'h05, 8'h12, "R4 setup");
    i2c_start(); send_byte(8'hD0, 1'b0, "R4"); send_byte(8'h05, 1'b0, "R4");
    wbit(1'b1); wbit(1'b0); wbit(1'b1); wbit(1'b0); i2c_stop();
    rd1(8'h05, 8'h12, "R4 partial byte ignored");

    // R5: unimplemented address
    wr1(8'h15, 8'hFF, "R5 write unimpl");
    rd1(8'h15, 8'h00, "R5 read unimpl");

    // R6: no keys, then keyed write, then key consumed
    wr1(8'h22, 8'h3C, "R6 unkeyed");
    rd1(8'h22, 8'h00, "R6 unkeyed blocked");
    i2c_start(); send_byte(8'hD0, 1'b0, "R6"); send_byte(8'h20, 1'b0, "R6");
    send_byte(8'h5E, 1'b0, "R6"); send_byte(8'hC7, 1'b0, "R6"); i2c_stop();
    wr1(8'h22, 8'h3C, "R6 keyed");
    rd1(8'h22, 8'h3C, "R6 keyed write");
    wr1(8'h22, 8'h99, "R6 reuse");
    rd1(8'h22, 8'h3C, "R6 key used up");
    rd1(8'h20, 8'h00, "R5 key A reads 0");
    rd1(8'h21, 8'h00, "R5 key B reads 0");

    // R7: wrong order through repeated STARTs
    i2c_start(); send_byte(8'hD0, 1'b0, "R7"); send_byte(8'h21, 1'b0, "R7"); send_byte(8'hC7, 1'b0, "R7");
    i2c_start(); send_byte(8'hD0, 1'b0, "R7"); send_byte(8'h20, 1'b0, "R7"); send_byte(8'h5E, 1'b0, "R7");
    i2c_start(); send_byte(8'hD0, 1'b0, "R7"); send_byte(8'h22, 1'b0, "R7"); send_byte(8'h11, 1'b0, "R7");
    i2c_stop();
    rd1(8'h22, 8'h3C, "R7 wrong order");
    // R7: wrong second key
    i2c_start(); send_byte(8'hD0, 1'b0, "R7"); send_byte(8'h20, 1'b0, "R7");
    send_byte(8'h5E, 1'b0, "R7"); send_byte(8'hC6, 1'b0, "R7"); i2c_stop();
    wr1(8'h22, 8'h11, "R7");
    rd1(8'h22, 8'h3C, "R7 wrong key value");
    // R7: STOP between keys
    wr1(8'h20, 8'h5E, "R7"); wr1(8'h21, 8'hC7, "R7"); wr1(8'h22, 8'h11, "R7");
    rd1(8'h22, 8'h3C, "R7 stop between keys");

    // R6 burst unlock and write, R3 wrap 22 -> 20
    i2c_start(); send_byte(8'hD0, 1'b0, "R6"); send_byte(8'h20, 1'b0, "R6");
    send_byte(8'h5E, 1'b0, "R6"); send_byte(8'hC7, 1'b0, "R6"); send_byte(8'h77, 1'b0, "R6");
    i2c_stop();
    i2c_start(); send_byte(8'hD0, 1'b0, "R3"); send_byte(8'h22, 1'b0, "R3");
    i2c_start(); send_byte(8'hD1, 1'b0, "R3");
    recv_byte(1'b0, 8'h77, "R6 burst keyed write"); recv_byte(1'b0, 8'h00, "R3 wrap to 20");
    recv_byte(1'b0, 8'h00, "R3 rd 21"); recv_byte(1'b1, 8'h77, "R3 rd 22 again"); i2c_stop();

    // R8: backup fence
    wr1(8'h01, 8'h44, "R8 setup");
    backup = 1'b1;
    rd1(8'h01, 8'h00, "R8 masked read");
    wr1(8'h01, 8'h55, "R8 blocked write");
    wr1(8'h07, 8'h66, "R8 open reg write");
    rd1(8'h07, 8'h66, "R8 open reg read");
    backup = 1'b0;
    rd1(8'h01, 8'h44, "R8 value kept");

    // R9: repeated START inside a data byte
    wr1(8'h02, 8'h5A, "R9 setup");
    i2c_start(); send_byte(8'hD0, 1'b0, "R9"); send_byte(8'h02, 1'b0, "R9");
    wbit(1'b0); wbit(1'b1); wbit(1'b1);
    i2c_start(); send_byte(8'hD1, 1'b0, "R9 addr after rs");
    recv_byte(1'b1, 8'h5A, "R9 read after rs"); i2c_stop();

    repeat (10) @(negedge clk);
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++; errors++;
      $display("FAIL %s: got nothing expected %02h", e.tag, e.v);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule